// File: doc/BRIEF.md
# Routed Periodic Local Timer

This block is a periodic down-counting timer that sits inside a multi-core interrupt controller. Software programs a reload value together with a run bit and an interrupt-enable bit through a small register bus. The count advances once for every cycle on which the tick-enable input is high; that input stands in for a 38.4 MHz reference, so one count is one reference tick. Each time the count expires, a sticky interrupt flag is set and the countdown starts again from the reload value.

The flag stays set until software clears it by writing a separate acknowledge register. The same acknowledge write can also restart the countdown. A routing register sends the timer interrupt to one of the cores, either as a normal IRQ or as a fast FIQ. The interrupt appears as bit 11 of that core's source word.

Top module: `rlt_timer_top`

## Requirements
- R1: After reset the routing register and the control register both read as zero, the countdown is stopped, and every IRQ and FIQ source bit is low.
- R2: A write to the control register (byte offset 0x34) with bit 28 (run) set and a nonzero reload value in bits 27:0 starts a countdown from that value. After exactly that many counted ticks, bit 31 (flag) is set and a new countdown begins from the reload value, so expiries repeat with that period.
- R3: The count moves only on clock edges where tick_en is high. On other edges the count holds.
- R4: A write to the control register with bit 28 clear stops the countdown, and no further expiry follows.
- R5: A reload value of zero never starts the countdown, even when bit 28 is set, and the flag is then never raised by the timer.
- R6: The flag is sticky. Only a control-register write or a write to the acknowledge register (byte offset 0x38) with bit 31 set clears it.
- R7: An acknowledge write with bit 30 set restarts the countdown from the reload value when bit 28 is set and the reload value is nonzero. When bit 28 is clear, that bit has no effect.
- R8: When an expiry and an acknowledge flag-clear happen on the same edge, the flag ends up set.
- R9: The routing register (byte offset 0x24) keeps only bits 2:0. Bits 1:0 name the target core, and bit 2 selects FIQ when set and IRQ when clear. At most one source bit in the whole block is high at any time.
- R10: Bit 11 of the routed core's IRQ or FIQ source word is high exactly when both bit 29 (interrupt enable) and bit 31 (flag) of the control register are set. All other source bits stay low.
- R11: Reads return the stored routing bits and the full stored control word. Reads of the acknowledge offset and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe; each high cycle is one reference tick |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_src | output | 48 | Per-core IRQ source words, 12 bits per core, core 0 in the low bits |
| fiq_src | output | 48 | Per-core FIQ source words, same packing as irq_src |

## Verification
The bench builds the block with its default parameters: four cores, a 28-bit reload field and 12-bit source words with the timer at bit 11. With these defaults every routing code, both the IRQ and the FIQ path, and every core slot can be reached. Short reload values of one to five ticks make repeated expiries, same-edge collisions between an expiry and an acknowledge, and mid-count restarts occur within a few dozen cycles. The cycle model in the bench is compared with both source vectors on every edge, and it drives the collision tests by waiting for its own count to reach its last tick.

// File: rtl/rlt_pkg.sv
package rlt_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ADDR_W    = 8;
    localparam logic [7:0]  OFS_ROUTE = 8'h24;
    localparam logic [7:0]  OFS_CTRL  = 8'h34;
    localparam logic [7:0]  OFS_ACK   = 8'h38;
    localparam int unsigned BIT_FLAG  = 31;
    localparam int unsigned BIT_RST   = 30;
    localparam int unsigned BIT_IE    = 29;
    localparam int unsigned BIT_RUN   = 28;
endpackage

// File: rtl/rlt_ctrl.sv
module rlt_ctrl
    import rlt_pkg::*;
#(
    parameter int unsigned VAL_W   = 28,
    parameter int unsigned ROUTE_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                expire_i,
    output logic [DATA_W-1:0]   ctrl_o,
    output logic [ROUTE_W-1:0]  route_o,
    output logic                load_o,
    output logic [VAL_W-1:0]    load_val_o,
    output logic                stop_o
);
    typedef struct packed {
        logic [DATA_W-1:0]  ctrl;
        logic [ROUTE_W-1:0] route;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  hit_ctrl, hit_ack, hit_route;

    assign hit_ctrl  = bus_we && (bus_addr == OFS_CTRL);
    assign hit_ack   = bus_we && (bus_addr == OFS_ACK);
    assign hit_route = bus_we && (bus_addr == OFS_ROUTE);

    always_comb begin
        regs_d     = regs_q;
        load_o     = 1'b0;
        stop_o     = 1'b0;
        load_val_o = regs_q.ctrl[VAL_W-1:0];
        if (hit_route) begin
            regs_d.route = bus_wdata[ROUTE_W-1:0];
        end
        if (hit_ctrl) begin
            regs_d.ctrl = bus_wdata;
            if (bus_wdata[BIT_RUN] && (bus_wdata[VAL_W-1:0] != '0)) begin
                load_o     = 1'b1;
                load_val_o = bus_wdata[VAL_W-1:0];
            end else begin
                stop_o = 1'b1;
            end
        end else begin
            if (expire_i) begin
                regs_d.ctrl[BIT_FLAG] = 1'b1;
            end else if (hit_ack && bus_wdata[BIT_FLAG]) begin
                regs_d.ctrl[BIT_FLAG] = 1'b0;
            end
            if (hit_ack && bus_wdata[BIT_RST] && regs_q.ctrl[BIT_RUN]
                && (regs_q.ctrl[VAL_W-1:0] != '0)) begin
                load_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_ROUTE: bus_rdata = DATA_W'(regs_q.route);
            OFS_CTRL:  bus_rdata = regs_q.ctrl;
            default:   bus_rdata = '0;
        endcase
    end

    assign ctrl_o  = regs_q.ctrl;
    assign route_o = regs_q.route;

    // R6: a set flag survives every edge without a clearing write
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.ctrl[BIT_FLAG] && !hit_ctrl && !(hit_ack && bus_wdata[BIT_FLAG])
        |=> regs_q.ctrl[BIT_FLAG]);

    // R8: an expiry sets the flag even against an acknowledge clear
    a_r8_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i && !hit_ctrl |=> regs_q.ctrl[BIT_FLAG]);

    // R9: routing register never holds more than its own bits
    a_r9_route_write: assert property (@(posedge clk) disable iff (!rst_n)
        hit_route |=> regs_q.route == $past(bus_wdata[ROUTE_W-1:0]));
endmodule

// File: rtl/rlt_counter.sv
module rlt_counter #(
    parameter int unsigned VAL_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [VAL_W-1:0] load_val_i,
    input  logic             stop_i,
    input  logic [VAL_W-1:0] reload_i,
    output logic             expire_o,
    output logic             running_o
);
    typedef struct packed {
        logic [VAL_W-1:0] cnt;
        logic             run;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic last_tick;

    assign last_tick = cnt_q.run && tick_i && (cnt_q.cnt == VAL_W'(1));
    assign expire_o  = last_tick;
    assign running_o = cnt_q.run;

    always_comb begin
        cnt_d = cnt_q;
        if (stop_i) begin
            cnt_d.run = 1'b0;
        end else if (load_i) begin
            cnt_d.cnt = load_val_i;
            cnt_d.run = 1'b1;
        end else if (cnt_q.run && tick_i) begin
            if (last_tick) begin
                cnt_d.cnt = reload_i;
            end else begin
                cnt_d.cnt = cnt_q.cnt - VAL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R5: a running countdown never holds zero
    a_r5_no_zero_run: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.run |-> cnt_q.cnt != '0);

    // R3: without a tick the count holds
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.run && !tick_i && !load_i && !stop_i |=> $stable(cnt_q.cnt));

    // R2: an expiry restarts from the reload value
    a_r2_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o && !load_i && !stop_i |=> cnt_q.cnt == $past(reload_i));

    // R4: a stop request halts the countdown
    a_r4_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !cnt_q.run);
endmodule

// File: rtl/rlt_router.sv
module rlt_router #(
    parameter int unsigned NCORES  = 4,
    parameter int unsigned SRC_W   = 12,
    parameter int unsigned SRC_BIT = 11,
    parameter int unsigned CORE_W  = 2
) (
    input  logic                    active_i,
    input  logic [CORE_W:0]         route_i,
    output logic [NCORES*SRC_W-1:0] irq_o,
    output logic [NCORES*SRC_W-1:0] fiq_o
);
    logic [NCORES-1:0] sel;

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        assign sel[c] = active_i && (route_i[CORE_W-1:0] == CORE_W'(c));
        for (genvar b = 0; b < SRC_W; b++) begin : g_bit
            if (b == SRC_BIT) begin : g_tmr
                assign irq_o[c*SRC_W+b] = sel[c] && !route_i[CORE_W];
                assign fiq_o[c*SRC_W+b] = sel[c] &&  route_i[CORE_W];
            end else begin : g_zero
                assign irq_o[c*SRC_W+b] = 1'b0;
                assign fiq_o[c*SRC_W+b] = 1'b0;
            end
        end
    end

    // R9: one destination at most
    always_comb begin
        if (!$isunknown({irq_o, fiq_o})) begin
            a_r9_single_target: assert ($onehot0({irq_o, fiq_o}));
        end
    end
endmodule

// File: rtl/rlt_timer_top.sv
module rlt_timer_top
    import rlt_pkg::*;
#(
    parameter int unsigned NCORES  = 4,
    parameter int unsigned VAL_W   = 28,
    parameter int unsigned SRC_W   = 12,
    parameter int unsigned SRC_BIT = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_en,
    input  logic [7:0]              bus_addr,
    input  logic                    bus_we,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic [NCORES*SRC_W-1:0] irq_src,
    output logic [NCORES*SRC_W-1:0] fiq_src
);
    localparam int unsigned CORE_W  = (NCORES > 1) ? $clog2(NCORES) : 1;
    localparam int unsigned ROUTE_W = CORE_W + 1;

    logic [DATA_W-1:0]  ctrl;
    logic [ROUTE_W-1:0] route;
    logic               load, stop, expire, running;
    logic [VAL_W-1:0]   load_val;
    logic               active;

    rlt_ctrl #(.VAL_W(VAL_W), .ROUTE_W(ROUTE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .expire_i(expire),
        .ctrl_o(ctrl), .route_o(route),
        .load_o(load), .load_val_o(load_val), .stop_o(stop)
    );

    rlt_counter #(.VAL_W(VAL_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_en),
        .load_i(load), .load_val_i(load_val), .stop_i(stop),
        .reload_i(ctrl[VAL_W-1:0]),
        .expire_o(expire), .running_o(running)
    );

    assign active = ctrl[BIT_IE] && ctrl[BIT_FLAG];

    rlt_router #(.NCORES(NCORES), .SRC_W(SRC_W), .SRC_BIT(SRC_BIT),
                 .CORE_W(CORE_W)) u_route (
        .active_i(active), .route_i(route),
        .irq_o(irq_src), .fiq_o(fiq_src)
    );

    // R10: no source without enable and flag
    a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl[BIT_IE] && ctrl[BIT_FLAG]) |-> ({irq_src, fiq_src} == '0));

    // R5: zero reload with run set never starts the count
    a_r5_zero_start: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == OFS_CTRL && bus_wdata[VAL_W-1:0] == '0
        |=> !running);
endmodule

// File: tb/sim_rlt_timer_top.sv
`timescale 1ns/1ps
module sim_rlt_timer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [47:0] irq_src, fiq_src;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] m_ctrl;
    int          m_route;
    int          m_cnt;
    bit          m_run;

    always #2.5 clk = ~clk;

    rlt_timer_top u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_src(irq_src), .fiq_src(fiq_src)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        bit expire;
        int val;
        val = int'(m_ctrl[27:0]);
        expire = m_run && tick_en && (m_cnt == 1);
        if (bus_we && bus_addr == 8'h24) m_route = int'(bus_wdata[2:0]);
        if (bus_we && bus_addr == 8'h34) begin
            m_ctrl = bus_wdata;
            if (bus_wdata[28] && bus_wdata[27:0] != 0) begin
                m_cnt = int'(bus_wdata[27:0]);
                m_run = 1;
            end else begin
                m_run = 0;
            end
        end else begin
            if (bus_we && bus_addr == 8'h38 && bus_wdata[30] && m_ctrl[28] && val != 0) begin
                m_cnt = val;
                m_run = 1;
            end else if (m_run && tick_en) begin
                m_cnt = (m_cnt == 1) ? val : m_cnt - 1;
            end
            if (expire) m_ctrl[31] = 1'b1;
            else if (bus_we && bus_addr == 8'h38 && bus_wdata[31]) m_ctrl[31] = 1'b0;
        end
    endtask

    task automatic step();
        logic [47:0] ei, ef;
        @(posedge clk);
        model_edge();
        #1;
        ei = '0;
        ef = '0;
        if (m_ctrl[29] && m_ctrl[31]) begin
            if (m_route[2]) ef[(m_route & 3) * 12 + 11] = 1'b1;
            else            ei[(m_route & 3) * 12 + 11] = 1'b1;
        end
        check("R10 irq", {16'h0, irq_src}, {16'h0, ei});
        check("R9 fiq", {16'h0, fiq_src}, {16'h0, ef});
    endtask

    task automatic idle(input bit t, input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = t;
            bus_we = 1'b0;
            step();
        end
        tick_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit t);
        bus_addr = a;
        bus_wdata = d;
        bus_we = 1'b1;
        tick_en = t;
        step();
        bus_we = 1'b0;
        tick_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_we = 1'b0;
        bus_addr = a;
        #0.5;
        check(tag, {32'h0, bus_rdata}, {32'h0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        m_ctrl = '0; m_route = 0; m_cnt = 0; m_run = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd("R1 route", 8'h24, 32'h0);
        rd("R1 ctrl", 8'h34, 32'h0);
        check("R1 sources", {16'h0, irq_src | fiq_src}, 64'h0);
        idle(1, 3);

        // R9 routing keeps low bits, R11 ack reads zero
        wr(8'h24, 32'hFFFF_FFF9, 0);
        rd("R9 route mask", 8'h24, 32'h1);
        rd("R11 ack read", 8'h38, 32'h0);
        rd("R11 unmapped", 8'h40, 32'h0);

        // R2 periodic expiry with period 3, core 1 IRQ
        wr(8'h34, 32'h3000_0003, 0);
        rd("R11 ctrl read", 8'h34, 32'h3000_0003);
        idle(1, 2);
        rd("R2 no flag before period", 8'h34, 32'h3000_0003);
        idle(1, 1);
        rd("R2 flag at period", 8'h34, 32'hB000_0003);
        check("R10 routed bit", {16'h0, irq_src}, 64'h1 << 23);

        // R6 sticky flag, cleared by ack
        wr(8'h38, 32'h0, 1);
        rd("R6 non-clearing ack", 8'h34, m_ctrl);
        check("R6 flag kept", {63'h0, m_ctrl[31]}, 64'h1);
        wr(8'h38, 32'h8000_0000, 0);
        rd("R6 ack clears", 8'h34, 32'h3000_0003);
        idle(1, 7);

        // R3 sparse ticks
        wr(8'h38, 32'h8000_0000, 0);
        wr(8'h34, 32'h3000_0002, 0);
        for (int i = 0; i < 4; i++) begin
            idle(0, 2);
            idle(1, 1);
            if (i == 0) rd("R3 one tick only", 8'h34, 32'h3000_0002);
            if (i == 1) check("R3 flag after two ticks", {63'h0, m_ctrl[31]}, 64'h1);
        end
        rd("R3 ctrl", 8'h34, m_ctrl);

        // R8 expiry vs ack clear on same edge
        wr(8'h34, 32'h3000_0004, 0);
        while (!(m_run && m_cnt == 1)) idle(1, 1);
        wr(8'h38, 32'h8000_0000, 1);
        rd("R8 expiry wins", 8'h34, 32'hB000_0004);

        // R7 ack restart
        wr(8'h34, 32'h3000_0005, 1);
        idle(1, 3);
        wr(8'h38, 32'h4000_0000, 1);
        idle(1, 4);
        rd("R7 restart delays expiry", 8'h34, 32'h3000_0005);
        idle(1, 1);
        rd("R7 expiry after restart", 8'h34, 32'hB000_0005);
        // R7 restart ignored while stopped
        wr(8'h34, 32'h2000_0002, 0);
        wr(8'h38, 32'h4000_0000, 1);
        idle(1, 8);
        rd("R7 no restart when stopped", 8'h34, 32'h2000_0002);

        // R4 stop mid-count
        wr(8'h34, 32'h3000_0003, 1);
        idle(1, 1);
        wr(8'h34, 32'h2000_0003, 1);
        idle(1, 10);
        rd("R4 stopped", 8'h34, 32'h2000_0003);

        // R5 zero reload never runs
        wr(8'h34, 32'h3000_0000, 1);
        idle(1, 20);
        rd("R5 zero reload", 8'h34, 32'h3000_0000);
        wr(8'h38, 32'h4000_0000, 1);
        idle(1, 5);
        rd("R5 zero after ack", 8'h34, 32'h3000_0000);

        // R10 enable gating and R9 FIQ routing on each core
        wr(8'h34, 32'h8000_0000, 0);
        check("R10 no enable", {16'h0, irq_src | fiq_src}, 64'h0);
        for (int r = 0; r < 8; r++) begin
            wr(8'h24, 32'(r), 0);
            wr(8'h34, 32'hA000_0000, 0);
            if (r[2]) check("R9 fiq target", {16'h0, fiq_src}, 64'h1 << (r[1:0] * 12 + 11));
            else      check("R9 irq target", {16'h0, irq_src}, 64'h1 << (r[1:0] * 12 + 11));
        end
        idle(1, 3);
        finish_run();
    end
endmodule